// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Tracker

This block follows the clock-enable pin of an SDRAM device and keeps a model of which low-power or stalled mode the device is in. At every rising clock edge it looks at two clock-enable samples: the one taken at the previous edge and the one present now. It combines that pair with the mode held just before the edge, a decoded command and a coarse activity flag. From these it moves between normal operation, power-down, self refresh, a timed self-refresh exit window and clock suspend. It flags every combination that a legal controller would never produce.

A memory controller or a protocol monitor places it beside the command path. The `mode` output shows where the device stands. `cmd_accept` tells the controller whether a command issued now would be honoured. `illegal` pulses for one cycle after any edge whose inputs break the clock-enable rules. The self-refresh exit window is counted in clock cycles by a parameter. Inside that window, every edge must carry a no-operation, and a minimum number of no-operations must be seen before the device counts as idle again.

Top module: `cke_power_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at an edge) gives `mode`=0 (idle), `cmd_accept`=1 and `illegal`=0 after that edge. The stored previous clock-enable sample becomes high, so a low `cke` at the first edge after reset counts as a high-to-low transition.
- R2: If `cke` was low at the previous edge and is still low, a device in power-down (2), self refresh (3) or clock suspend (5) keeps its mode and raises no flag, whatever the `cmd` and `busy_rw` values.
- R3: A low-to-high `cke` change in power-down, with `cmd`=0 (no-operation or inhibit), returns `mode` to 0 with `cmd_accept`=1 after that edge.
- R4: A low-to-high `cke` change in clock suspend, with any `cmd` other than 3, gives `mode`=1 (active read/write) and `cmd_accept`=1 after that edge.
- R5: A low-to-high `cke` change in self refresh, with `cmd`=0, gives `mode`=4 (self-refresh exit) with `cmd_accept`=0. The mode stays 4 for `SR_EXIT_CYCLES` further high-`cke` edges, and after the last of them `mode`=0 and `cmd_accept`=1.
- R6: Inside the exit window, an edge whose `cmd` is not 0 pulses `illegal` and the count still advances. If fewer than `MIN_EXIT_NOPS` no-operations were counted by the last window edge, that edge pulses `illegal` as well, and the mode still returns to 0.
- R7: A high-to-low `cke` change from mode 0 or 1 with `busy_rw`=0 enters power-down (2) when `cmd`=0, and self refresh (3) when `cmd`=1 (auto refresh).
- R8: A high-to-low `cke` change from mode 0 or 1 with `busy_rw`=1 and `cmd` in 0..2 enters clock suspend (5).
- R9: While `cke` stays high in mode 0 or 1, `mode` follows `busy_rw` (1 when high, 0 when low) and `illegal` stays low for `cmd` in 0..2.
- R10: Any other combination pulses `illegal` for one cycle and leaves `mode` unchanged. This covers `cmd`=2 on a high-to-low change while idle, a non-zero `cmd` when leaving power-down, and `cmd`=3 (reserved) at any edge with `cke` high.
- R11: `mode` uses the codes 0 idle, 1 active read/write, 2 power-down, 3 self refresh, 4 self-refresh exit, 5 clock suspend. `cmd_accept` is high exactly when `mode` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock-enable sample for the current edge |
| cmd | input | 2 | Decoded command: 0 no-op/inhibit, 1 auto refresh, 2 other valid, 3 reserved |
| busy_rw | input | 1 | Activity: 1 reading or writing, 0 all banks idle |
| mode | output | 3 | Current mode code (see R11) |
| cmd_accept | output | 1 | High when a command at the next edge would be honoured |
| illegal | output | 1 | One-cycle pulse after an edge that broke the rules |

## Verification
The main table steps through all four clock-enable sample pairs: held low, rising, falling and held high. It combines each pair with every mode in which the pair is legal and with the command that selects the mode entered. This tells entry into power-down apart from entry into self refresh and from clock suspend. A clean self-refresh exit, made only of no-operations, is run next to one filled with other commands, which separates the per-edge flag from the too-few-no-operations flag at the window's end. Directed runs hold power-down while `cmd` and `busy_rw` cycle through all their values. They also reset in the middle of an exit window and then drop `cke` at once, which shows that the previous sample was forced high.

// File: rtl/cke_trk_pkg.sv
package cke_trk_pkg;

  typedef enum logic [2:0] {
    M_IDLE         = 3'd0,
    M_ACTIVE_RW    = 3'd1,
    M_POWER_DOWN   = 3'd2,
    M_SELF_REFRESH = 3'd3,
    M_SR_EXIT      = 3'd4,
    M_CLK_SUSPEND  = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    C_NOP      = 2'd0,
    C_AUTO_REF = 2'd1,
    C_OTHER    = 2'd2,
    C_RSVD     = 2'd3
  } cmd_e;

  // Pair {previous sample, current sample}
  typedef enum logic [1:0] {
    E_STAY_LOW  = 2'd0,
    E_RISE      = 2'd1,
    E_FALL      = 2'd2,
    E_STAY_HIGH = 2'd3
  } cke_pair_e;

endpackage

// File: rtl/cke_edge_sampler.sv
module cke_edge_sampler
  import cke_trk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cke,
  output cke_pair_e pair_kind,
  output logic      cke_prev
);

  always_ff @(posedge clk) begin
    if (rst) cke_prev <= 1'b1;
    else     cke_prev <= cke;
  end

  always_comb begin
    if (cke_prev) pair_kind = cke ? E_STAY_HIGH : E_FALL;
    else          pair_kind = cke ? E_RISE : E_STAY_LOW;
  end

endmodule

// File: rtl/sr_exit_window.sv
module sr_exit_window #(
  parameter int unsigned EXIT_CYCLES = 10,
  parameter int unsigned MIN_NOPS    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic step,
  input  logic is_nop,
  output logic at_last,
  output logic nops_short
);

  localparam int unsigned CW = $clog2(EXIT_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                         cnt_q <= '0;
    else if (start)                  cnt_q <= CW'(EXIT_CYCLES);
    else if (step && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign at_last = (cnt_q == CW'(1));

  generate
    if (MIN_NOPS == 0) begin : g_no_nop_floor
      assign nops_short = 1'b0;
    end else begin : g_nop_floor
      localparam int unsigned NW = $clog2(MIN_NOPS + 1);
      logic [NW-1:0] nop_q;
      logic [NW:0]   nop_sum;

      always_ff @(posedge clk) begin
        if (rst || start)
          nop_q <= '0;
        else if (step && is_nop && nop_q != NW'(MIN_NOPS))
          nop_q <= nop_q + 1'b1;
      end

      assign nop_sum    = {1'b0, nop_q} + {{NW{1'b0}}, is_nop};
      assign nops_short = nop_sum < (NW+1)'(MIN_NOPS);
    end
  endgenerate

endmodule

// File: rtl/cke_mode_fsm.sv
module cke_mode_fsm
  import cke_trk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cke_pair_e pair_kind,
  input  logic [1:0] cmd,
  input  logic      busy_rw,
  input  logic      win_at_last,
  input  logic      win_short,
  output mode_e     mode_q,
  output logic      accept_q,
  output logic      illegal_q,
  output logic      win_start,
  output logic      win_step
);

  cmd_e  cmd_w;
  mode_e nxt;
  logic  bad;
  logic  is_nop, is_rsvd, running;

  assign cmd_w   = cmd_e'(cmd);
  assign is_nop  = (cmd_w == C_NOP);
  assign is_rsvd = (cmd_w == C_RSVD);
  assign running = (mode_q == M_IDLE) || (mode_q == M_ACTIVE_RW);

  always_comb begin
    nxt       = mode_q;
    bad       = 1'b0;
    win_start = 1'b0;
    win_step  = 1'b0;
    unique case (pair_kind)
      E_STAY_LOW: begin
        if (!(mode_q == M_POWER_DOWN || mode_q == M_SELF_REFRESH ||
              mode_q == M_CLK_SUSPEND))
          bad = 1'b1;
      end
      E_RISE: begin
        case (mode_q)
          M_POWER_DOWN: begin
            if (is_nop) nxt = M_IDLE;
            else        bad = 1'b1;
          end
          M_CLK_SUSPEND: begin
            if (!is_rsvd) nxt = M_ACTIVE_RW;
            else          bad = 1'b1;
          end
          M_SELF_REFRESH: begin
            if (is_nop) begin
              nxt       = M_SR_EXIT;
              win_start = 1'b1;
            end else begin
              bad = 1'b1;
            end
          end
          default: bad = 1'b1;
        endcase
      end
      E_FALL: begin
        if (running && !is_rsvd) begin
          if (busy_rw)                  nxt = M_CLK_SUSPEND;
          else if (is_nop)              nxt = M_POWER_DOWN;
          else if (cmd_w == C_AUTO_REF) nxt = M_SELF_REFRESH;
          else                          bad = 1'b1;
        end else begin
          bad = 1'b1;
        end
      end
      E_STAY_HIGH: begin
        if (running) begin
          if (is_rsvd) bad = 1'b1;
          else         nxt = busy_rw ? M_ACTIVE_RW : M_IDLE;
        end else if (mode_q == M_SR_EXIT) begin
          win_step = 1'b1;
          if (!is_nop) bad = 1'b1;
          if (win_at_last) begin
            nxt = M_IDLE;
            if (win_short) bad = 1'b1;
          end
        end else begin
          bad = 1'b1;
        end
      end
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_IDLE;
      accept_q  <= 1'b1;
      illegal_q <= 1'b0;
    end else begin
      mode_q    <= nxt;
      accept_q  <= (nxt == M_IDLE) || (nxt == M_ACTIVE_RW);
      illegal_q <= bad;
    end
  end

endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_trk_pkg::*;
#(
  parameter int unsigned SR_EXIT_CYCLES = 10,
  parameter int unsigned MIN_EXIT_NOPS  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic [1:0] cmd,
  input  logic       busy_rw,
  output logic [2:0] mode,
  output logic       cmd_accept,
  output logic       illegal
);

  cke_pair_e pair_kind;
  logic      cke_prev_q;
  logic      win_start, win_step, win_at_last, win_short;
  mode_e     mode_q;

  cke_edge_sampler u_sampler (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .pair_kind (pair_kind),
    .cke_prev  (cke_prev_q)
  );

  sr_exit_window #(
    .EXIT_CYCLES (SR_EXIT_CYCLES),
    .MIN_NOPS    (MIN_EXIT_NOPS)
  ) u_window (
    .clk        (clk),
    .rst        (rst),
    .start      (win_start),
    .step       (win_step),
    .is_nop     (cmd == 2'd0),
    .at_last    (win_at_last),
    .nops_short (win_short)
  );

  cke_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pair_kind   (pair_kind),
    .cmd         (cmd),
    .busy_rw     (busy_rw),
    .win_at_last (win_at_last),
    .win_short   (win_short),
    .mode_q      (mode_q),
    .accept_q    (cmd_accept),
    .illegal_q   (illegal),
    .win_start   (win_start),
    .win_step    (win_step)
  );

  assign mode = mode_q;

endmodule

// File: rtl/cke_tracker_checker.sv
module cke_tracker_checker (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic [1:0] cmd,
  input logic       busy_rw,
  input logic [2:0] mode,
  input logic       cmd_accept,
  input logic       illegal,
  input logic       cke_prev
);

  p_mode_code_r11: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd5);

  p_accept_match_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_accept == (mode == 3'd0 || mode == 3'd1));

  p_hold_low_r2: assert property (@(posedge clk) disable iff (rst)
    (!cke_prev && !cke && (mode == 3'd2 || mode == 3'd3 || mode == 3'd5))
    |=> (mode == $past(mode) && !illegal));

  p_pd_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (!cke_prev && cke && mode == 3'd2 && cmd == 2'd0)
    |=> (mode == 3'd0 && cmd_accept));

  p_cs_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (!cke_prev && cke && mode == 3'd5 && cmd != 2'd3) |=> mode == 3'd1);

  p_sr_exit_start_r5: assert property (@(posedge clk) disable iff (rst)
    (!cke_prev && cke && mode == 3'd3 && cmd == 2'd0)
    |=> (mode == 3'd4 && !cmd_accept));

  p_window_nop_r6: assert property (@(posedge clk) disable iff (rst)
    (cke_prev && cke && mode == 3'd4 && cmd != 2'd0) |=> illegal);

  p_suspend_entry_r8: assert property (@(posedge clk) disable iff (rst)
    (cke_prev && !cke && busy_rw && cmd != 2'd3 && (mode == 3'd0 || mode == 3'd1))
    |=> mode == 3'd5);

  p_reserved_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (cke && cmd == 2'd3) |=> illegal);

endmodule

bind cke_power_tracker cke_tracker_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .cke        (cke),
  .cmd        (cmd),
  .busy_rw    (busy_rw),
  .mode       (mode),
  .cmd_accept (cmd_accept),
  .illegal    (illegal),
  .cke_prev   (cke_prev_q)
);

// File: tb/cke_power_tracker_tb_top.sv
`timescale 1ns/1ps
module cke_power_tracker_tb_top;

  localparam int unsigned EXIT_CYC = 4;
  localparam int NV = 34;

  // {req[3:0], rst, cke, cmd[1:0], busy, mode[2:0], accept, illegal}
  function automatic logic [13:0] v(int req, bit r, bit k, int c, bit b,
                                    int m, bit a, bit i);
    return {4'(req), r, k, 2'(c), b, 3'(m), a, i};
  endfunction

  localparam logic [13:0] VEC [NV] = '{
    v(1, 1,1,0,0, 0,1,0),   // R1 reset
    v(9, 0,1,2,1, 1,1,0),   // R9 busy -> active
    v(9, 0,1,2,0, 0,1,0),   // R9 idle again
    v(7, 0,0,0,0, 2,0,0),   // R7 power-down entry
    v(2, 0,0,2,0, 2,0,0),   // R2 hold
    v(2, 0,0,3,0, 2,0,0),   // R2 hold, reserved ignored
    v(3, 0,1,0,0, 0,1,0),   // R3 power-down exit
    v(7, 0,0,1,0, 3,0,0),   // R7 self refresh entry
    v(2, 0,0,2,0, 3,0,0),   // R2 hold
    v(5, 0,1,0,0, 4,0,0),   // R5 exit window opens
    v(5, 0,1,0,0, 4,0,0),
    v(5, 0,1,0,0, 4,0,0),
    v(5, 0,1,0,0, 4,0,0),
    v(5, 0,1,0,0, 0,1,0),   // R5 window done
    v(9, 0,1,2,1, 1,1,0),
    v(8, 0,0,2,1, 5,0,0),   // R8 clock suspend entry
    v(2, 0,0,1,1, 5,0,0),   // R2 hold
    v(4, 0,1,2,1, 1,1,0),   // R4 suspend exit
    v(9, 0,1,2,0, 0,1,0),
    v(10,0,0,2,0, 0,1,1),   // R10 fall while idle with other cmd
    v(10,0,0,0,0, 0,1,1),   // R10 low-low in idle
    v(10,0,1,0,0, 0,1,1),   // R10 rise in idle
    v(9, 0,1,0,0, 0,1,0),
    v(10,0,1,3,0, 0,1,1),   // R10 reserved
    v(9, 0,1,0,0, 0,1,0),
    v(7, 0,0,0,0, 2,0,0),
    v(10,0,1,1,0, 2,0,1),   // R10 power-down exit with refresh
    v(1, 1,1,0,0, 0,1,0),   // R1 reset recovers
    v(7, 0,0,1,0, 3,0,0),
    v(5, 0,1,0,0, 4,0,0),
    v(6, 0,1,2,0, 4,0,1),   // R6 non-nop in window
    v(6, 0,1,2,0, 4,0,1),
    v(6, 0,1,2,0, 4,0,1),
    v(6, 0,1,0,0, 0,1,1)    // R6 too few nops at window end
  };

  logic       clk = 1'b0;
  logic       rst, cke, busy_rw;
  logic [1:0] cmd;
  logic [2:0] mode;
  logic       cmd_accept, illegal;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  cke_power_tracker #(.SR_EXIT_CYCLES(EXIT_CYC), .MIN_EXIT_NOPS(2)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .busy_rw(busy_rw),
    .mode(mode), .cmd_accept(cmd_accept), .illegal(illegal)
  );

  task automatic check(int req, logic [2:0] em, logic ea, logic ei);
    n_tests++;
    if (mode !== em || cmd_accept !== ea || illegal !== ei) begin
      n_fail++;
      $display("FAIL R%0d: mode=%0d accept=%0b illegal=%0b, expected mode=%0d accept=%0b illegal=%0b",
               req, mode, cmd_accept, illegal, em, ea, ei);
    end
  endtask

  task automatic drive(bit r, bit k, int c, bit b);
    rst = r; cke = k; cmd = 2'(c); busy_rw = b;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; cke = 1'b1; cmd = 2'd0; busy_rw = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [13:0] e;
      e = VEC[i];
      drive(e[9], e[8], int'(e[7:6]), e[5]);
      check(int'(e[13:10]), e[4:2], e[1], e[0]);
    end

    // R1: reset mid exit window, then previous sample counts as high
    drive(0, 0, 1, 0);
    drive(0, 1, 0, 0);
    drive(0, 1, 0, 0);
    drive(1, 0, 0, 0);
    check(1, 3'd0, 1'b1, 1'b0);   // R1
    drive(0, 0, 0, 0);
    check(1, 3'd2, 1'b0, 1'b0);   // R1 falling pair enters power-down

    // R2: long power-down hold across every cmd and busy value
    for (int i = 0; i < 20; i++) begin
      drive(0, 0, i % 4, (i % 2) == 1);
      check(2, 3'd2, 1'b0, 1'b0); // R2
    end

    drive(0, 1, 0, 1);
    check(3, 3'd0, 1'b1, 1'b0);   // R3 exit ignores busy

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule